// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request/response interface and an external asynchronous static RAM of 2048 bytes. A client offers a single-word read or write together with an 11-bit address, write data and a small tag. The controller turns that request into the active-low chip-enable, write-enable and output-enable sequence the memory expects. It drives the address lines, controls the enable of the shared bidirectional data bus, and captures read data. Read data comes back on a one-cycle response strobe carrying the tag of the request.

Every timing interval counts system clock cycles and is set by a parameter: read cycle length, read access time, chip-enable lead before the write strobe, write-strobe width, post-write recovery and read-to-write turnaround. Writes are timed by the write-enable strobe. Write enable only falls while chip enable is already low, so it is always the strobe that ends the write. Data is driven from the first cycle of the strobe and held until one cycle after the strobe rises, which meets both setup and hold at the terminating edge. Between requests chip enable is high, so the memory drops into its standby state.

Top module: `sram_bus_ctrl`

## Requirements
- R1: The memory address space is 2^ADDR_W words (2048 with the default ADDR_W = 11) of DATA_W bits. Each write stores its data at the address it names, and each read returns the data last written there.
- R2: `req_ready` is high only when the controller is idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until the whole operation has completed.
- R3: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for exactly RD_CYCLE_CYC cycles. `sram_dq_in` is sampled at the end of the RD_ACCESS_CYC-th of those cycles. `rsp_valid` is high in the next cycle with the sampled byte on `rsp_rdata` and the request's tag on `rsp_tag`.
- R4: A write keeps `sram_ce_n` low throughout. First `sram_we_n` stays high for the setup phase, then it is low for exactly WE_PULSE_CYC cycles, then high again for WR_HOLD_CYC cycles before chip enable is released.
- R5: During a write `sram_oe_n` stays high. `sram_dq_oe` is high in every cycle in which `sram_we_n` is low and in the first cycle after `sram_we_n` rises, and low in all other cycles.
- R6: The setup phase lasts WR_SETUP_CYC cycles. When the previous operation was a read (or always, if TURN_ALWAYS is set), it lasts WR_SETUP_CYC + TURN_CYC cycles, so the memory has released the bus before the controller drives it.
- R7: While idle, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high and `sram_dq_oe` is low.
- R8: `sram_addr` does not change while `sram_ce_n` stays low. `sram_dq_out` does not change while `sram_dq_oe` stays high.
- R9: `sram_we_n` is never low unless `sram_ce_n` is low. `sram_dq_oe` is never high while `sram_oe_n` is low.
- R10: `rsp_valid` is a single-cycle pulse, raised once per read and never for a write.
- R11: After reset `req_ready` is high, `rsp_valid` is low and all memory strobes are in the idle state of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Request identifier returned with read data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Read data |
| rsp_tag | output | TAG_W | Tag of the completed read |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Data driven onto the shared bus |
| sram_dq_oe | output | 1 | Controller drives the shared bus when high |
| sram_dq_in | input | DATA_W | Value observed on the shared bus |

## Verification
With the read access count equal to the read cycle count, the read response strobe falls in the same cycle in which the controller returns to idle and can accept the next request. The bench issues its next request immediately after every read, so during the sweeps a new write or read is accepted in the very cycle in which the previous read's byte and tag are being delivered. It judges the response by data and tag against its own shadow copy. It then checks that the new operation's strobes start on the following cycle with the full, turnaround-extended setup phase and no contention on the shared bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_WSET  = 3'd2,
      ST_WPUL  = 3'd3,
      ST_WREC  = 3'd4
   } ctrl_state_e;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } pin_ctl_t;

   localparam pin_ctl_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last,
   output logic [CNT_W-1:0] remaining
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q > CNT_W'(1)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last      = (cnt_q <= CNT_W'(1));
   assign remaining = cnt_q;

endmodule

// File: rtl/sram_pin_ctl.sv
module sram_pin_ctl
   import sram_ctrl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  ctrl_state_e cur_st,
   input  ctrl_state_e nxt_st,
   output logic        ce_n,
   output logic        oe_n,
   output logic        we_n,
   output logic        dq_oe
);

   pin_ctl_t pins_d;
   pin_ctl_t pins_q;

   always_comb begin
      pins_d = PINS_IDLE;
      unique case (nxt_st)
         ST_RD: begin
            pins_d.ce_n = 1'b0;
            pins_d.oe_n = 1'b0;
         end
         ST_WSET: begin
            pins_d.ce_n = 1'b0;
         end
         ST_WPUL: begin
            pins_d.ce_n  = 1'b0;
            pins_d.we_n  = 1'b0;
            pins_d.dq_oe = 1'b1;
         end
         ST_WREC: begin
            pins_d.ce_n  = 1'b0;
            pins_d.dq_oe = (cur_st == ST_WPUL);
         end
         default: pins_d = PINS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= PINS_IDLE;
      else        pins_q <= pins_d;
   end

   assign ce_n  = pins_q.ce_n;
   assign oe_n  = pins_q.oe_n;
   assign we_n  = pins_q.we_n;
   assign dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 11,
   parameter int DATA_W        = 8,
   parameter int TAG_W         = 4,
   parameter int RD_CYCLE_CYC  = 2,
   parameter int RD_ACCESS_CYC = 2,
   parameter int WR_SETUP_CYC  = 1,
   parameter int WE_PULSE_CYC  = 2,
   parameter int WR_HOLD_CYC   = 1,
   parameter int TURN_CYC      = 1,
   parameter bit TURN_ALWAYS   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   localparam int CNT_MAX = max2(max2(RD_CYCLE_CYC, WR_SETUP_CYC + TURN_CYC),
                                 max2(WE_PULSE_CYC, WR_HOLD_CYC));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LD_RD       = CNT_W'(RD_CYCLE_CYC);
   localparam logic [CNT_W-1:0] LD_SET      = CNT_W'(WR_SETUP_CYC);
   localparam logic [CNT_W-1:0] LD_SET_TURN = CNT_W'(WR_SETUP_CYC + TURN_CYC);
   localparam logic [CNT_W-1:0] LD_PUL      = CNT_W'(WE_PULSE_CYC);
   localparam logic [CNT_W-1:0] LD_HOLD     = CNT_W'(WR_HOLD_CYC);
   localparam logic [CNT_W-1:0] CAP_AT      = CNT_W'(RD_CYCLE_CYC - RD_ACCESS_CYC + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("sram_bus_ctrl: widths must be at least 1");
   end
   if (RD_ACCESS_CYC < 1 || RD_ACCESS_CYC > RD_CYCLE_CYC) begin : g_bad_read
      $error("sram_bus_ctrl: need 1 <= RD_ACCESS_CYC <= RD_CYCLE_CYC");
   end
   if (WR_SETUP_CYC < 1 || WE_PULSE_CYC < 1 || WR_HOLD_CYC < 1) begin : g_bad_write
      $error("sram_bus_ctrl: write phases need at least one cycle each");
   end
   if (TURN_CYC < 1) begin : g_bad_turn
      $error("sram_bus_ctrl: TURN_CYC must be at least 1");
   end

   ctrl_state_e       state_q, state_d;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_last;
   logic [CNT_W-1:0]  tmr_rem;
   logic              accept;
   logic              capture;
   logic              last_rd_q;
   logic              turn_needed;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rsp_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   if (TURN_ALWAYS) begin : g_turn_always
      assign turn_needed = 1'b1;
   end else begin : g_turn_after_read
      assign turn_needed = last_rd_q;
   end

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WSET;
                  tmr_val = turn_needed ? LD_SET_TURN : LD_SET;
               end else begin
                  state_d = ST_RD;
                  tmr_val = LD_RD;
               end
            end
         end
         ST_RD: begin
            capture = (tmr_rem == CAP_AT);
            if (tmr_last) state_d = ST_IDLE;
         end
         ST_WSET: begin
            if (tmr_last) begin
               state_d  = ST_WPUL;
               tmr_load = 1'b1;
               tmr_val  = LD_PUL;
            end
         end
         ST_WPUL: begin
            if (tmr_last) begin
               state_d  = ST_WREC;
               tmr_load = 1'b1;
               tmr_val  = LD_HOLD;
            end
         end
         ST_WREC: begin
            if (tmr_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         tag_q     <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            tag_q     <= req_tag;
            last_rd_q <= !req_write;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= capture;
         if (capture) rdata_q <= sram_dq_in;
      end
   end

   sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .load_val  (tmr_val),
      .last      (tmr_last),
      .remaining (tmr_rem)
   );

   sram_pin_ctl u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_st (state_q),
      .nxt_st (state_d),
      .ce_n   (sram_ce_n),
      .oe_n   (sram_oe_n),
      .we_n   (sram_we_n),
      .dq_oe  (sram_dq_oe)
   );

   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;
   assign rsp_tag     = tag_q;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic [DATA_W-1:0] sram_dq_out,
   input logic              sram_dq_oe
);

   // R2: an accepted request drops ready on the next cycle
   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R3: output enable only with chip enable low and write enable high
   p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (!sram_ce_n && sram_we_n));

   // R5: the bus is driven during the strobe
   p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_dq_oe);

   // R5: release one cycle after the strobe rises
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_dq_oe && sram_we_n) |=> !sram_dq_oe);

   // R7: idle strobes
   p_idle_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

   // R8: address stable while selected
   p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   // R8: driven data stable
   p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

   // R9: write strobe only while selected
   p_we_needs_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_ce_n);

   // R9: no contention on the shared bus
   p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> sram_oe_n);

   // R10: response is a single-cycle pulse
   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .sram_addr   (sram_addr),
   .sram_ce_n   (sram_ce_n),
   .sram_oe_n   (sram_oe_n),
   .sram_we_n   (sram_we_n),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

   localparam int AW = 11, DW = 8, TW = 4;
   localparam int RDC = 2, RDA = 2, SET = 1, PUL = 2, HLD = 1, TRN = 1;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [TW-1:0] req_tag = '0;
   logic req_ready, rsp_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
   logic [TW-1:0] rsp_tag;
   logic [AW-1:0] sram_addr;

   int n_checks = 0, n_fail = 0;
   int rd_low = 0;
   int contention = 0;
   bit prev_wr = 1'b0;
   bit last_was_read = 1'b0;
   bit done = 1'b0;
   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] shadow [WORDS];

   always #10 clk = ~clk;   // 50 MHz

   sram_bus_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .RD_CYCLE_CYC(RDC), .RD_ACCESS_CYC(RDA),
      .WR_SETUP_CYC(SET), .WE_PULSE_CYC(PUL), .WR_HOLD_CYC(HLD), .TURN_CYC(TRN),
      .TURN_ALWAYS(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   // memory model: data valid only after RDA selected cycles, garbage before
   always_comb begin
      if (sram_dq_oe)                                        sram_dq_in = sram_dq_out;
      else if (!sram_ce_n && !sram_oe_n && rd_low >= RDA)    sram_dq_in = mem[sram_addr];
      else                                                   sram_dq_in = 8'h5A;
   end

   always @(negedge clk) begin
      if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_low <= rd_low + 1;
      else                                       rd_low <= 0;
      if (sram_dq_oe && !sram_oe_n && !sram_ce_n) contention <= contention + 1;
      if (prev_wr && !(!sram_ce_n && !sram_we_n))
         mem[sram_addr] <= sram_dq_oe ? sram_dq_out : 8'hEE;
      prev_wr <= !sram_ce_n && !sram_we_n;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return DW'((a * 13) ^ (a >> 3) ^ salt);
   endfunction

   task automatic do_write(input int a, input logic [DW-1:0] d, input int t);
      int exp_set, set_n, pul_n, rec_n, k;
      bit drv_ok, rsp_seen, oe_ok;
      exp_set = last_was_read ? SET + TRN : SET;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_tag = TW'(t);
      @(negedge clk);
      req_valid = 1'b0;
      set_n = 0; pul_n = 0; rec_n = 0; drv_ok = 1; rsp_seen = 0; oe_ok = 1;
      for (k = 0; k < 20 && sram_we_n && !sram_ce_n; k++) begin
         set_n++; if (sram_dq_oe) drv_ok = 0; if (!sram_oe_n) oe_ok = 0;
         if (rsp_valid) rsp_seen = 1; @(negedge clk);
      end
      for (k = 0; k < 20 && !sram_we_n; k++) begin
         pul_n++; if (!sram_dq_oe || sram_dq_out != d) drv_ok = 0; if (!sram_oe_n) oe_ok = 0;
         if (rsp_valid) rsp_seen = 1; @(negedge clk);
      end
      for (k = 0; k < 20 && !sram_ce_n; k++) begin
         rec_n++;
         if ((rec_n == 1) != sram_dq_oe) drv_ok = 0; if (!sram_oe_n) oe_ok = 0;
         if (rsp_valid) rsp_seen = 1; @(negedge clk);
      end
      check(set_n == exp_set, "R6 setup length", set_n, exp_set);
      check(pul_n == PUL && rec_n == HLD, "R4 strobe/hold length", pul_n * 100 + rec_n, PUL * 100 + HLD);
      check(drv_ok && oe_ok, "R5 bus drive window", int'(drv_ok) + 2 * int'(oe_ok), 3);
      check(!rsp_seen, "R10 no response for write", int'(rsp_seen), 0);
      check(req_ready, "R2 ready after write", int'(req_ready), 1);
      shadow[a] = d;
      last_was_read = 1'b0;
   endtask

   task automatic do_read(input int a, input int t);
      int ce_n_cnt, rsp_k, rsp_cnt;
      bit strobe_ok, rdy_ok;
      logic [DW-1:0] got_d; logic [TW-1:0] got_t;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_tag = TW'(t);
      @(negedge clk);
      req_valid = 1'b0;
      ce_n_cnt = 0; rsp_k = 0; rsp_cnt = 0; strobe_ok = 1; rdy_ok = 1; got_d = '0; got_t = '0;
      for (int k = 1; k <= RDC + 1; k++) begin
         if (k <= RDC) begin
            if (!sram_ce_n) ce_n_cnt++;
            if (sram_oe_n || !sram_we_n) strobe_ok = 0;
            if (req_ready) rdy_ok = 0;
         end else begin
            if (!sram_ce_n || !sram_oe_n || !req_ready) strobe_ok = 0;
         end
         if (rsp_valid) begin rsp_k = k; rsp_cnt++; got_d = rsp_rdata; got_t = rsp_tag; end
         if (k <= RDC) @(negedge clk);
      end
      check(ce_n_cnt == RDC && strobe_ok, "R3 read strobes", ce_n_cnt, RDC);
      check(rdy_ok, "R2 ready low during read", int'(rdy_ok), 1);
      check(rsp_k == RDA + 1 && rsp_cnt == 1, "R10 response timing", rsp_k * 10 + rsp_cnt, (RDA + 1) * 10 + 1);
      check(got_d == shadow[a], "R1 read data", int'(got_d), int'(shadow[a]));
      check(got_t == TW'(t), "R3 tag", int'(got_t), t);
      last_was_read = 1'b1;
   endtask

   initial begin
      for (int i = 0; i < WORDS; i++) begin
         mem[i] = DW'(i * 7 + 3);
         shadow[i] = DW'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      // R11 / R7: reset state
      check(req_ready && !rsp_valid, "R11 reset ready/rsp", int'(req_ready), 1);
      check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R11 reset strobes",
            int'({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}), 14);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(5, 3);
      for (int a = 0; a < WORDS; a++) do_write(a, pat(a, 1), a);
      for (int a = 0; a < WORDS; a++) do_read(a, a);
      for (int a = 0; a < 64; a++) begin
         do_read(a * 31 % WORDS, a);
         do_write(a * 31 % WORDS, ~pat(a, 2), a);
         do_write((a * 31 + 1) % WORDS, pat(a, 3), a);
         do_read(a * 31 % WORDS, a + 1);
      end
      do_read(WORDS - 1, 15);
      do_read(0, 0);
      // R7: idle with no request
      repeat (5) begin
         @(negedge clk);
         check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready, "R7 idle standby",
               int'({sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}), 14);
      end
      check(contention == 0, "R9 bus contention", contention, 0);
      done = 1'b1;
   end

   initial begin
      int cyc;
      for (cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      end
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule